// File: doc/BRIEF.md
# In-order completion tracker for renamed instructions

This block records every renamed instruction in program order until it may commit. Each cycle the rename stage can hand it up to four instructions, each carrying the logical register it writes and the physical register that logical register mapped to before. The tracker gives each one a slot index. Execution units report completion by returning that index, in any order.

Instructions leave from the oldest end only, up to four per cycle. Retirement stops at the first instruction that has not finished. As each one leaves, its superseded physical register is handed back for reuse.

Recovery comes in two forms. A mispredicted branch cuts away every instruction younger than the branch. An instruction that completed with a fault stops retirement when it becomes the oldest. That instruction then raises a flush covering itself and everything behind it.

Both the dispatch side and the retire side use a valid/ready handshake. On the dispatch side, `disp_ready` falls whenever fewer than four slots are free. It also falls in any cycle where a flush or a mispredict is being taken, and no instruction is accepted while it is low. On the retire side, the lanes in `ret_valid` are offered together and leave together at a clock edge where `ret_ready` is high. While `ret_ready` is low, the offered entries stay in place.

Top module: `active_list`

## Requirements
- R1: After reset the list is empty. `disp_ready` is 1, `ret_valid` is 0, `exc_flush` is 0, and dispatch lane 0 is offered slot index 0.
- R2: When `disp_valid` and `disp_ready` are both high at a clock edge, the first `disp_count` lanes are written into consecutive slots. Lane i receives index (next free index + i) modulo 32, and that index is shown on `disp_tag` lane i in the same cycle. Indices wrap from 31 to 0.
- R3: The list never holds more than 32 entries. `disp_ready` is low whenever more than 28 entries are held.
- R4: `ret_valid` is a contiguous group of lanes starting at lane 0, holding at most four lanes. Lane i stands for the (i+1)-th oldest entry. The group ends before the first entry that is not done or that carries a fault.
- R5: Retire lane i carries the logical register and the superseded physical register that were dispatched with that entry. Entries leave in exactly the order they were dispatched.
- R6: While `ret_ready` is low, no entry leaves. Every lane already offered stays offered, unless a mispredict or flush occurs.
- R7: A completion report on `cpl_valid`/`cpl_tag` marks that slot done. A done entry behind an unfinished older entry is not offered until the older one is done.
- R8: When the oldest entry is done with its fault bit (`cpl_exc` = 1) set, it is not offered. `exc_flush` is 1 and `exc_tag` holds its index. At the next edge the list becomes empty, and the next dispatch index equals that faulting index.
- R9: In a cycle with `mp_valid` high, no entry is offered and no dispatch is accepted. At the edge, every entry younger than `mp_tag` is discarded, and the next dispatch index becomes `mp_tag` + 1.
- R10: A handshake with `disp_count` = 0 adds no entry and leaves the next dispatch index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch group present |
| disp_ready | output | 1 | At least four free slots and no recovery this cycle |
| disp_count | input | 3 | Number of valid lanes in the group (above 4 taken as 4) |
| disp_lreg | input | 20 | Logical destination per lane, 5 bits each, lane 0 in the low bits |
| disp_old_ptag | input | 24 | Superseded physical register per lane, 6 bits each |
| disp_tag | output | 20 | Slot index assigned to each lane, 5 bits each |
| cpl_valid | input | 4 | Completion report valid, one per port |
| cpl_tag | input | 20 | Slot index being completed, 5 bits per port |
| cpl_exc | input | 4 | Completed instruction faulted |
| mp_valid | input | 1 | Branch mispredict recovery request |
| mp_tag | input | 5 | Slot index of the mispredicted branch (kept) |
| ret_valid | output | 4 | Retire lanes offered, contiguous from lane 0 |
| ret_ready | input | 1 | Free list accepts all offered lanes |
| ret_lreg | output | 20 | Logical destination per retire lane |
| ret_old_ptag | output | 24 | Physical register released per retire lane |
| exc_flush | output | 1 | Oldest entry faulted; flush it and all younger |
| exc_tag | output | 5 | Slot index of the faulting entry |

## Verification
The results follow from the state after each edge. Slot indices on `disp_tag` are valid in the same cycle that the group is offered. An accepted entry occupies its slot from the next edge on. A completion reported at one edge makes the entry eligible in the very next cycle, and it leaves at the following edge where `ret_ready` is high. A fault flush shows in the first cycle that the faulting entry is oldest, and the list is empty one edge later. The bench drives inputs one time unit after the rising edge and reads every output at the falling edge of the same cycle. A scoreboard queue is filled at each accepted dispatch, trimmed on a mispredict, cleared on a flush, and popped lane by lane whenever `ret_valid` and `ret_ready` are both high.

// File: rtl/actlist_pkg.sv
package actlist_pkg;
  localparam int unsigned LREG_W = 5;
  localparam int unsigned PTAG_W = 6;

  typedef logic [LREG_W-1:0] lreg_t;
  typedef logic [PTAG_W-1:0] ptag_t;

  typedef struct packed {
    lreg_t lreg;
    ptag_t old_ptag;
  } slot_rec_t;
endpackage

// File: rtl/al_alloc.sv
module al_alloc #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LANES = 4
) (
  input  logic [$clog2(DEPTH)-1:0]       tail,
  input  logic                           fire,
  input  logic [$clog2(LANES+1)-1:0]     req_n,
  output logic [LANES*$clog2(DEPTH)-1:0] lane_tag,
  output logic [LANES-1:0]               lane_we,
  output logic [$clog2(LANES+1)-1:0]     acc_n
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(LANES+1);

  logic [CW-1:0] clamp_n;
  assign clamp_n = (req_n > CW'(LANES)) ? CW'(LANES) : req_n;
  assign acc_n   = fire ? clamp_n : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_tag[l*IDX_W +: IDX_W] = tail + IDX_W'(l);
    assign lane_we[l] = fire && (CW'(l) < clamp_n);
  end
endmodule

// File: rtl/al_store.sv
module al_store
  import actlist_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned LANES     = 4,
  parameter int unsigned CPL_PORTS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [LANES-1:0]                   lane_we,
  input  logic [LANES*$clog2(DEPTH)-1:0]     lane_tag,
  input  slot_rec_t                          lane_rec [LANES],
  input  logic [CPL_PORTS-1:0]               cpl_valid,
  input  logic [CPL_PORTS*$clog2(DEPTH)-1:0] cpl_tag,
  input  logic [CPL_PORTS-1:0]               cpl_exc,
  output logic [DEPTH-1:0]                   done_vec,
  output logic [DEPTH-1:0]                   exc_vec,
  output slot_rec_t                          rec_q [DEPTH]
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_vec[e] <= 1'b0;
        exc_vec[e]  <= 1'b0;
        rec_q[e]    <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_we[l] && (lane_tag[l*IDX_W +: IDX_W] == IDX_W'(e))) begin
            rec_q[e]    <= lane_rec[l];
            done_vec[e] <= 1'b0;
            exc_vec[e]  <= 1'b0;
          end
        end
        for (int p = 0; p < CPL_PORTS; p++) begin
          if (cpl_valid[p] && (cpl_tag[p*IDX_W +: IDX_W] == IDX_W'(e))) begin
            done_vec[e] <= 1'b1;
            exc_vec[e]  <= cpl_exc[p];
          end
        end
      end
    end
  end
endmodule

// File: rtl/al_retire_sel.sv
module al_retire_sel #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LANES = 4
) (
  input  logic [$clog2(DEPTH)-1:0]   head,
  input  logic [$clog2(DEPTH):0]     occ,
  input  logic [DEPTH-1:0]           done_vec,
  input  logic [DEPTH-1:0]           exc_vec,
  output logic [LANES-1:0]           ok_mask,
  output logic [$clog2(LANES+1)-1:0] ok_n,
  output logic                       head_fault
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned CW    = $clog2(LANES+1);

  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    go      = 1'b1;
    ok_mask = '0;
    ok_n    = '0;
    for (int i = 0; i < LANES; i++) begin
      idx = head + IDX_W'(i);
      if (go && (CNT_W'(i) < occ) && done_vec[idx] && !exc_vec[idx]) begin
        ok_mask[i] = 1'b1;
        ok_n       = ok_n + CW'(1);
      end else begin
        go = 1'b0;
      end
    end
    head_fault = (occ != '0) && done_vec[head] && exc_vec[head];
  end
endmodule

// File: rtl/active_list.sv
module active_list
  import actlist_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned LANES     = 4,
  parameter int unsigned CPL_PORTS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               disp_valid,
  output logic                               disp_ready,
  input  logic [$clog2(LANES+1)-1:0]         disp_count,
  input  logic [LANES*LREG_W-1:0]            disp_lreg,
  input  logic [LANES*PTAG_W-1:0]            disp_old_ptag,
  output logic [LANES*$clog2(DEPTH)-1:0]     disp_tag,
  input  logic [CPL_PORTS-1:0]               cpl_valid,
  input  logic [CPL_PORTS*$clog2(DEPTH)-1:0] cpl_tag,
  input  logic [CPL_PORTS-1:0]               cpl_exc,
  input  logic                               mp_valid,
  input  logic [$clog2(DEPTH)-1:0]           mp_tag,
  output logic [LANES-1:0]                   ret_valid,
  input  logic                               ret_ready,
  output logic [LANES*LREG_W-1:0]            ret_lreg,
  output logic [LANES*PTAG_W-1:0]            ret_old_ptag,
  output logic                               exc_flush,
  output logic [$clog2(DEPTH)-1:0]           exc_tag
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned CW    = $clog2(LANES+1);

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;

  logic             fire;
  logic [LANES-1:0] lane_we;
  logic [CW-1:0]    acc_n;
  logic [LANES-1:0] ok_mask;
  logic [CW-1:0]    ok_n;
  logic             head_fault;
  logic [CW-1:0]    ret_n;
  logic [IDX_W-1:0] mp_span;

  logic [DEPTH-1:0] done_vec, exc_vec;
  slot_rec_t        rec_q    [DEPTH];
  slot_rec_t        lane_rec [LANES];

  assign disp_ready = (cnt <= CNT_W'(DEPTH - LANES)) && !head_fault && !mp_valid;
  assign fire       = disp_valid && disp_ready;

  al_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
    .tail     (tail),
    .fire     (fire),
    .req_n    (disp_count),
    .lane_tag (disp_tag),
    .lane_we  (lane_we),
    .acc_n    (acc_n)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_in
    assign lane_rec[l] = {disp_lreg[l*LREG_W +: LREG_W], disp_old_ptag[l*PTAG_W +: PTAG_W]};
  end

  al_store #(.DEPTH(DEPTH), .LANES(LANES), .CPL_PORTS(CPL_PORTS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .lane_tag  (disp_tag),
    .lane_rec  (lane_rec),
    .cpl_valid (cpl_valid),
    .cpl_tag   (cpl_tag),
    .cpl_exc   (cpl_exc),
    .done_vec  (done_vec),
    .exc_vec   (exc_vec),
    .rec_q     (rec_q)
  );

  al_retire_sel #(.DEPTH(DEPTH), .LANES(LANES)) u_sel (
    .head       (head),
    .occ        (cnt),
    .done_vec   (done_vec),
    .exc_vec    (exc_vec),
    .ok_mask    (ok_mask),
    .ok_n       (ok_n),
    .head_fault (head_fault)
  );

  assign ret_valid = mp_valid ? '0 : ok_mask;
  assign ret_n     = (ret_ready && !mp_valid) ? ok_n : '0;
  assign exc_flush = head_fault;
  assign exc_tag   = head;
  assign mp_span   = mp_tag - head;

  for (genvar l = 0; l < LANES; l++) begin : g_out
    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = head + IDX_W'(l);
    assign ret_lreg[l*LREG_W +: LREG_W]     = rec_q[rd_idx].lreg;
    assign ret_old_ptag[l*PTAG_W +: PTAG_W] = rec_q[rd_idx].old_ptag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (head_fault) begin
      tail <= head;
      cnt  <= '0;
    end else if (mp_valid) begin
      tail <= mp_tag + IDX_W'(1);
      cnt  <= {1'b0, mp_span} + CNT_W'(1);
    end else begin
      head <= head + IDX_W'(ret_n);
      tail <= tail + IDX_W'(acc_n);
      cnt  <= cnt + CNT_W'(acc_n) - CNT_W'(ret_n);
    end
  end
endmodule

// File: rtl/al_checker.sv
module al_checker #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_ready,
  input logic                   mp_valid,
  input logic                   exc_flush,
  input logic                   ret_ready,
  input logic [LANES-1:0]       ret_valid,
  input logic [$clog2(DEPTH):0] occ
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_stall_when_tight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ > CNT_W'(DEPTH - LANES)) |-> !disp_ready);

  assert_ret_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ret_valid) |-> (ret_valid[0] && (((ret_valid + 1'b1) & ret_valid) == '0)));

  assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ret_valid) && !ret_ready && !mp_valid && !exc_flush)
      |=> (((ret_valid & $past(ret_valid)) == $past(ret_valid)) || mp_valid));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> (occ == '0));

  assert_mp_no_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid |-> (ret_valid == '0) && !disp_ready);
endmodule

bind active_list al_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_al_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_ready (disp_ready),
  .mp_valid   (mp_valid),
  .exc_flush  (exc_flush),
  .ret_ready  (ret_ready),
  .ret_valid  (ret_valid),
  .occ        (cnt)
);

// File: tb/active_list_bench.sv
`timescale 1ns/1ps
module active_list_bench;
  localparam int DEPTH = 32;
  localparam int LANES = 4;
  localparam int CPL   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [2:0]  disp_count = '0;
  logic [19:0] disp_lreg = '0;
  logic [23:0] disp_old_ptag = '0;
  logic [19:0] disp_tag;
  logic [3:0]  cpl_valid = '0;
  logic [19:0] cpl_tag = '0;
  logic [3:0]  cpl_exc = '0;
  logic        mp_valid = 1'b0;
  logic [4:0]  mp_tag = '0;
  logic [3:0]  ret_valid;
  logic        ret_ready = 1'b0;
  logic [19:0] ret_lreg;
  logic [23:0] ret_old_ptag;
  logic        exc_flush;
  logic [4:0]  exc_tag;

  always #2 clk = ~clk;

  active_list #(.DEPTH(DEPTH), .LANES(LANES), .CPL_PORTS(CPL)) u_active_list (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_count(disp_count),
    .disp_lreg(disp_lreg), .disp_old_ptag(disp_old_ptag), .disp_tag(disp_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_exc(cpl_exc),
    .mp_valid(mp_valid), .mp_tag(mp_tag),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_lreg(ret_lreg), .ret_old_ptag(ret_old_ptag),
    .exc_flush(exc_flush), .exc_tag(exc_tag)
  );

  typedef struct packed {
    logic [4:0] tag;
    logic [4:0] lreg;
    logic [5:0] ptag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, retired = 0, m_tail = 0, seq = 0;
  bit mon_on = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: pops one expected item per retiring lane
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (exc_flush) begin
        chk(q.size() > 0 && q[0].tag == exc_tag, "R8 flush tag", exc_tag,
            q.size() > 0 ? int'(q[0].tag) : -1);
        q.delete();
        m_tail = exc_tag;
      end
      if (ret_ready) begin
        for (int l = 0; l < LANES; l++) begin
          if (ret_valid[l]) begin
            if (q.size() == 0) chk(1'b0, "R5 unexpected retire", l, -1);
            else begin
              e = q.pop_front();
              retired++;
              chk(ret_lreg[l*5 +: 5] == e.lreg, "R5 lreg", ret_lreg[l*5 +: 5], e.lreg);
              chk(ret_old_ptag[l*6 +: 6] == e.ptag, "R5 old ptag", ret_old_ptag[l*6 +: 6], e.ptag);
            end
          end
        end
      end
    end
  end

  task automatic dispatch(input int n);
    exp_t e;
    disp_valid = 1'b1;
    disp_count = 3'(n);
    for (int i = 0; i < LANES; i++) begin
      disp_lreg[i*5 +: 5]     = 5'((seq + i) * 7 + 3);
      disp_old_ptag[i*6 +: 6] = 6'((seq + i) * 5 + 11);
    end
    @(negedge clk);
    for (int i = 0; i < LANES; i++)
      chk(disp_tag[i*5 +: 5] == 5'(m_tail + i), (n == 0) ? "R10 tag unchanged" : "R2 lane tag",
          disp_tag[i*5 +: 5], (m_tail + i) % DEPTH);
    if (disp_ready) begin
      for (int i = 0; i < n; i++) begin
        e.tag  = 5'(m_tail + i);
        e.lreg = disp_lreg[i*5 +: 5];
        e.ptag = disp_old_ptag[i*6 +: 6];
        q.push_back(e);
      end
      m_tail = (m_tail + n) % DEPTH;
      seq += n;
    end
    tick();
    disp_valid = 1'b0;
    disp_count = '0;
  endtask

  task automatic complete(input int tag, input bit exc);
    cpl_valid[0]   = 1'b1;
    cpl_tag[4:0]   = 5'(tag);
    cpl_exc[0]     = exc;
    tick();
    cpl_valid[0]   = 1'b0;
    cpl_exc[0]     = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int rbase;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(disp_ready == 1'b1, "R1 ready", disp_ready, 1);
    chk(ret_valid == 4'b0, "R1 ret_valid", ret_valid, 0);
    chk(exc_flush == 1'b0, "R1 flush", exc_flush, 0);
    chk(disp_tag[4:0] == 5'd0, "R1 first tag", disp_tag[4:0], 0);
    mon_on = 1'b1;
    tick();
    ret_ready = 1'b1;

    dispatch(4);
    dispatch(3);
    @(negedge clk);
    chk(ret_valid == 4'b0, "R4 nothing done", ret_valid, 0);
    tick();

    // R7 out-of-order completion waits for oldest
    complete(2, 0);
    complete(1, 0);
    @(negedge clk);
    chk(ret_valid == 4'b0, "R7 younger done waits", ret_valid, 0);
    tick();
    complete(0, 0);
    @(negedge clk);
    chk(ret_valid == 4'b0111, "R4 stop at first not done", ret_valid, 7);
    tick();

    // R6 back-pressure
    ret_ready = 1'b0;
    complete(3, 0);
    complete(4, 0);
    complete(5, 0);
    complete(6, 0);
    @(negedge clk);
    chk(ret_valid == 4'b1111, "R4 four lanes max", ret_valid, 15);
    rbase = retired;
    tick();
    @(negedge clk);
    chk(ret_valid == 4'b1111, "R6 offer held", ret_valid, 15);
    chk(retired == rbase, "R6 nothing left", retired, rbase);
    ret_ready = 1'b1;
    tick();
    @(negedge clk);
    chk(ret_valid == 4'b0 && q.size() == 0, "R4 all retired", q.size(), 0);
    tick();

    // R2/R3 fill with wrap
    for (int k = 0; k < 8; k++) dispatch(4);
    @(negedge clk);
    chk(disp_ready == 1'b0, "R3 full stall", disp_ready, 0);
    tick();
    dispatch(4);

    // R9 mispredict at tag 16 (entries 7..16 survive)
    ret_ready = 1'b0;
    complete(7, 0);
    mp_valid  = 1'b1;
    mp_tag    = 5'd16;
    ret_ready = 1'b1;
    @(negedge clk);
    chk(ret_valid == 4'b0, "R9 no retire during recovery", ret_valid, 0);
    chk(disp_ready == 1'b0, "R9 no dispatch during recovery", disp_ready, 0);
    while (q.size() > 0 && q[$].tag != 5'd16) void'(q.pop_back());
    m_tail = 17;
    tick();
    mp_valid = 1'b0;
    @(negedge clk);
    chk(ret_valid == 4'b0001, "R9 branch entries kept", ret_valid, 1);
    chk(disp_ready == 1'b1, "R9 space freed", disp_ready, 1);
    tick();
    dispatch(0);
    dispatch(2);

    // R8 fault at tag 10
    complete(8, 0);
    complete(9, 0);
    complete(10, 1);
    @(negedge clk);
    chk(exc_flush == 1'b1, "R8 flush raised", exc_flush, 1);
    chk(exc_tag == 5'd10, "R8 fault tag", exc_tag, 10);
    chk(ret_valid == 4'b0, "R8 fault not retired", ret_valid, 0);
    tick();
    @(negedge clk);
    chk(exc_flush == 1'b0 && disp_ready == 1'b1, "R8 list emptied", disp_ready, 1);
    chk(disp_tag[4:0] == 5'd10, "R8 tail reset", disp_tag[4:0], 10);
    tick();

    // reverse-order completion
    dispatch(4);
    complete(13, 0);
    complete(12, 0);
    complete(11, 0);
    @(negedge clk);
    chk(ret_valid == 4'b0, "R7 oldest pending", ret_valid, 0);
    tick();
    complete(10, 0);
    @(negedge clk);
    chk(ret_valid == 4'b1111, "R7 group released", ret_valid, 15);
    tick();
    @(negedge clk);
    chk(q.size() == 0, "R5 queue drained", q.size(), 0);
    chk(retired == 14, "R5 retire total", retired, 14);
    summary();
  end
endmodule